// File: doc/BRIEF.md
# Audio Master-Clock Divider

This block derives an audio bit clock and a sample (left/right) clock from a free-running master clock. A 3-bit ratio selector sets how many master-clock cycles make up one sample period. The choices cover the usual power-of-two and 1.5x audio ratios, plus the ratios 125, 250 and 272 that apply when the master clock comes from a USB-rate oscillator. For every ratio the frame holds exactly that many master-clock cycles. When the ratio is not a multiple of the number of bit-clock half-phases, a fractional accumulator spreads the spare cycles over the half-phases, so the bit clock has an uneven but bounded period pattern. For odd ratios the sample clock has a duty cycle other than 50:50.

Both clocks run continuously. A one-cycle strobe marks the first master-clock cycle of each sample period. The ratio input is sampled only on the edge that begins a frame, so a change written mid-frame takes effect at the next frame boundary. The bit clock carries 64 periods per frame. For the 125 ratio there are fewer than 128 cycles per frame, so it carries 32 periods.

Top module: `audclk_divider`

## Requirements
- R1: While rst_n is low, sclk, lrck and frame_strobe are all low. The first rising clock edge with rst_n high begins a frame.
- R2: ratio_sel selects the master-clock cycles per frame R as 0:125, 1:128, 2:192, 3:250, 4:256, 5:272, 6:384, 7:512. Consecutive frame strobes are exactly R cycles apart.
- R3: frame_strobe is high for exactly one cycle, in cycle 0 of each frame. In that cycle sclk and lrck are low.
- R4: With H = 128 half-phases when R >= 128 and H = 64 when R = 125, cycle c of a frame (0 <= c < R) lies in half-phase k = floor(c*H/R). sclk is high when k is odd, which gives H/2 sclk periods per frame with the low phase first.
- R5: Every sclk high or low phase lasts floor(R/H) or ceil(R/H) cycles, and never zero cycles.
- R6: lrck is low for the first ceil(R/2) cycles of a frame and high for the remaining floor(R/2) cycles. lrck rises only while sclk is low.
- R7: ratio_sel is sampled only on the edge that starts a frame. A change applied mid-frame leaves the current frame's length and phase pattern unchanged.
- R8: sclk, lrck and frame_strobe keep running frame after frame with no other input activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Free-running master clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| ratio_sel_i | input | 3 | Frame-length ratio selector (see R2) |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Sample (left/right) clock |
| frame_strobe_o | output | 1 | One-cycle pulse in the first cycle of each frame |

## Verification
Every output comes straight from a register, so each result belongs to the cycle that follows the rising edge that computed it. The bench advances its reference frame counter at each rising edge and compares all three outputs at the next falling edge. A ratio takes effect in the first cycle after the frame-start edge that samples it, and the bench model samples the selector on that same edge. Reset is asynchronous, so the outputs are expected low at the falling edge that follows reset assertion. Frame length and phase length are measured from the observed outputs themselves and compared with the ratio of the frame that just ended.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int MAX_RATIO      = 512;
  localparam int BITS_PER_FRAME = 64;
  localparam int HALF_PHASES    = 2 * BITS_PER_FRAME;
  localparam int SEL_W          = 3;
  localparam int RATIO_W        = $clog2(MAX_RATIO + 1);
  localparam int CNT_W          = $clog2(MAX_RATIO);
  localparam int IDX_W          = $clog2(HALF_PHASES);
  localparam int HP_W           = $clog2(HALF_PHASES + 1);

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [HP_W-1:0]    halves_t;
  typedef logic [SEL_W-1:0]   sel_t;

  // Selector code to master-clock cycles per frame.
  function automatic ratio_t decode_ratio(input sel_t sel);
    ratio_t r;
    case (sel)
      3'd0:    r = ratio_t'(125);
      3'd1:    r = ratio_t'(128);
      3'd2:    r = ratio_t'(192);
      3'd3:    r = ratio_t'(250);
      3'd4:    r = ratio_t'(256);
      3'd5:    r = ratio_t'(272);
      3'd6:    r = ratio_t'(384);
      default: r = ratio_t'(512);
    endcase
    return r;
  endfunction

  // Half-phases per frame: full count when the ratio allows one cycle each.
  function automatic halves_t halves_for(input ratio_t r);
    halves_t h;
    if (r >= ratio_t'(HALF_PHASES)) h = halves_t'(HALF_PHASES);
    else                            h = halves_t'(HALF_PHASES / 2);
    return h;
  endfunction
endpackage

// File: rtl/audclk_ratio_latch.sv
module audclk_ratio_latch
  import audclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_i,
  input  sel_t    sel_i,
  output ratio_t  ratio_o,
  output halves_t halves_o
);
  ratio_t  ratio_q,  ratio_d;
  halves_t halves_q, halves_d;

  always_comb begin
    ratio_d  = ratio_q;
    halves_d = halves_q;
    if (load_i) begin
      ratio_d  = decode_ratio(sel_i);
      halves_d = halves_for(ratio_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q  <= ratio_t'(MAX_RATIO);
      halves_q <= halves_t'(HALF_PHASES);
    end else begin
      ratio_q  <= ratio_d;
      halves_q <= halves_d;
    end
  end

  assign ratio_o  = ratio_q;
  assign halves_o = halves_q;

  // R7: the active ratio only moves on a frame-start edge
  assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ratio_q));
endmodule

// File: rtl/audclk_frame_counter.sv
module audclk_frame_counter
  import audclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_i,
  output logic   start_o,
  output logic   strobe_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             strobe_q;
  logic             last_cyc;

  always_comb begin
    last_cyc = ({1'b0, cnt_q} == (ratio_i - ratio_t'(1)));
    start_o  = !run_q || last_cyc;
    cnt_d    = start_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      run_q    <= 1'b1;
      cnt_q    <= cnt_d;
      strobe_q <= start_o;
    end
  end

  assign strobe_o = strobe_q;

  // R3: strobe never lasts two cycles (every ratio exceeds one)
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
endmodule

// File: rtl/audclk_phase_accum.sv
module audclk_phase_accum
  import audclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart_i,
  input  ratio_t  ratio_i,
  input  halves_t halves_i,
  output logic    sclk_o,
  output logic    lrck_o
);
  logic [RATIO_W-1:0] acc_q, acc_d;
  logic [RATIO_W:0]   sum;
  logic               step;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               lrck_q, lrck_d;
  logic [RATIO_W-1:0] run_q, run_d;

  always_comb begin
    sum  = {1'b0, acc_q} + (RATIO_W+1)'(halves_i);
    step = (sum >= {1'b0, ratio_i});
    if (restart_i) begin
      acc_d = '0;
      idx_d = '0;
    end else if (step) begin
      acc_d = RATIO_W'(sum - {1'b0, ratio_i});
      idx_d = idx_q + 1'b1;
    end else begin
      acc_d = RATIO_W'(sum);
      idx_d = idx_q;
    end
    lrck_d = (HP_W'(idx_d) >= (halves_i >> 1));
    run_d  = (restart_i || step) ? '0 : run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      idx_q  <= '0;
      lrck_q <= 1'b0;
      run_q  <= '0;
    end else begin
      acc_q  <= acc_d;
      idx_q  <= idx_d;
      lrck_q <= lrck_d;
      run_q  <= run_d;
    end
  end

  assign sclk_o = idx_q[0];
  assign lrck_o = lrck_q;

  // R5: a half-phase ending mid-frame lasts floor or ceil of ratio/halves
  assert_phase_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart_i) |->
      ((int'(run_q) + 1) * int'(halves_i) + int'(halves_i) > int'(ratio_i)) &&
      ((int'(run_q) + 1) * int'(halves_i) < int'(ratio_i) + int'(halves_i)));

  // R6: lrck rises at the start of a low sclk phase
  assert_lrck_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrck_q) |-> !idx_q[0]);
endmodule

// File: rtl/audclk_divider.sv
module audclk_divider
  import audclk_pkg::*;
(
  input  logic             mclk_i,
  input  logic             rst_n_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             sclk_o,
  output logic             lrck_o,
  output logic             frame_strobe_o
);
  ratio_t  ratio;
  halves_t halves;
  logic    frame_start;

  audclk_frame_counter u_frame (
    .clk      (mclk_i),
    .rst_n    (rst_n_i),
    .ratio_i  (ratio),
    .start_o  (frame_start),
    .strobe_o (frame_strobe_o)
  );

  audclk_ratio_latch u_ratio (
    .clk      (mclk_i),
    .rst_n    (rst_n_i),
    .load_i   (frame_start),
    .sel_i    (ratio_sel_i),
    .ratio_o  (ratio),
    .halves_o (halves)
  );

  audclk_phase_accum u_phase (
    .clk       (mclk_i),
    .rst_n     (rst_n_i),
    .restart_i (frame_start),
    .ratio_i   (ratio),
    .halves_i  (halves),
    .sclk_o    (sclk_o),
    .lrck_o    (lrck_o)
  );

  // R3: frame start sits in a low phase of both clocks
  assert_strobe_low_R3: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
    frame_strobe_o |-> (!sclk_o && !lrck_o));

  // R8: a strobe is followed by running clocks, never a stuck strobe
  assert_free_run_R8: assert property (@(posedge mclk_i) disable iff (!rst_n_i)
    frame_strobe_o |=> !frame_strobe_o);
endmodule

// File: tb/audclk_divider_tb.sv
module audclk_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       sclk, lrck, strobe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit m_run = 0;
  int m_c = 0, m_r = 512, m_h = 128;
  // observation state
  bit have_prev = 0;
  int gap = 0, last_r = 0, last_h = 0;
  bit prev_sclk = 0, run_ok = 0;
  int run_len = 0;

  always #5 clk = ~clk;

  audclk_divider u_dut (
    .mclk_i         (clk),
    .rst_n_i        (rst_n),
    .ratio_sel_i    (sel),
    .sclk_o         (sclk),
    .lrck_o         (lrck),
    .frame_strobe_o (strobe)
  );

  function automatic int exp_ratio(input logic [2:0] s);
    case (s)
      3'd0: return 125; 3'd1: return 128; 3'd2: return 192; 3'd3: return 250;
      3'd4: return 256; 3'd5: return 272; 3'd6: return 384; default: return 512;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // model advances on the same edge as the design
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_run = 0;
    else if (!m_run || m_c == m_r - 1) begin
      m_c = 0; m_r = exp_ratio(sel); m_h = (m_r >= 128) ? 128 : 64; m_run = 1;
    end else m_c++;
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!m_run) begin
      check(!sclk && !lrck && !strobe, "R1 outputs low in reset", {sclk, lrck, strobe}, 0);
      have_prev = 0; run_ok = 0; gap = 0;
    end else begin
      int k;
      k = (m_c * m_h) / m_r;
      check(sclk == k[0], "R4 sclk level", sclk, k[0]);
      check(lrck == (m_c >= (m_r + 1) / 2), "R6 lrck level", lrck, int'(m_c >= (m_r + 1) / 2));
      check(strobe == (m_c == 0), "R3 frame strobe", strobe, int'(m_c == 0));
      gap++;
      if (strobe) begin
        if (have_prev) check(gap == last_r, "R2 R7 R8 frame length", gap, last_r);
        have_prev = 1; gap = 0;
      end
      if (run_ok && sclk != prev_sclk) begin
        check((run_len * last_h + last_h > last_r) && (run_len * last_h < last_r + last_h),
              "R5 phase length", run_len, last_r / last_h);
        run_len = 0;
      end
      if (strobe) begin run_ok = 1; run_len = 0; end
      run_len++;
      prev_sclk = sclk; last_r = m_r; last_h = m_h;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!strobe);
    #1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    #1;
    idle(4);
    rst_n = 1'b1;                      // R1: first edge starts a frame
    // R2: every ratio, two full frames each
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      wait_strobe();
      wait_strobe();
      wait_strobe();
    end
    // R7: mid-frame change must not alter the running frame
    sel = 3'd5; wait_strobe();
    idle(40); sel = 3'd0; wait_strobe();
    idle(60); sel = 3'd7; wait_strobe();
    wait_strobe();
    // R1: reset in the middle of a frame
    idle(100); rst_n = 1'b0; idle(3); rst_n = 1'b1;
    wait_strobe(); wait_strobe();
    // R8: free running with no input activity
    idle(1500);
    // random ratio changes and occasional resets
    for (int i = 0; i < 70; i++) begin
      sel = 3'($urandom % 8);
      idle(1 + ($urandom % 700));
      if (($urandom % 16) == 0) begin
        rst_n = 1'b0; idle(2 + ($urandom % 3)); rst_n = 1'b1;
      end
    end
    idle(600);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule